// File: doc/BRIEF.md
# Receive Line Glitch Filter

This block cleans a single-bit serial receive line before it reaches a protocol decoder. The raw line first passes through a two-flop synchronizer on the interface clock. The synchronized level then drives an integrating up/down counter. The counter moves one step toward its top value on each cycle the line reads high, and one step toward zero on each cycle it reads low. The counter stops at both ends.

The filtered output is a latch with hysteresis. It goes high only on the edge where the counter arrives at its top value. It goes low only on the edge where the counter arrives at zero. Between those two points it keeps its value. A short pulse or a burst of noise therefore moves the counter part of the way but leaves the output alone.

The top value comes from a 3-bit prescale code. The code forms the upper bits, and the low four bits are always ones. A larger code gives a wider rejection window, at the cost of a longer delay before the output follows a real change.

Top module: `rx_glitch_filter`

## Requirements
- R1: While reset is asserted and after it is released, the filtered output is 0, the counter is 0 and both synchronizer flops are 0.
- R2: The raw input reaches the counter only through two synchronizer flops. A level applied before clock edge k is first used to step the counter on edge k+2.
- R3: The counter adds one on a high sample and subtracts one on a low sample. It never goes above the top value and never drops below 0. It holds at the top on a high sample and at 0 on a low sample.
- R4: The top value is {code[2:0], 4'b1111}, so the code forms bits 6:4 of the 7-bit counter. Code 2 gives 0x2F, code 0 gives 0x0F and code 7 gives 0x7F.
- R5: The output becomes 1 on the same edge that the counter reaches the top value.
- R6: The output becomes 0 on the same edge that the counter reaches 0.
- R7: The output holds its value while the counter lies strictly between 0 and the top value. Pulses shorter than a full traverse of the counter range never change it.
- R8: If the code changes so that the top value drops below the current count, the next edge loads the new top value into the counter and sets the output to 1.
- R9: Take a line held high from a count of 0. If it is applied before edge 1, the output first reads 1 after edge top+2. The same timing holds for a low line falling from the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 1 | Unsynchronized serial receive line |
| pre_code | input | 3 | Prescale code; supplies bits 6:4 of the top value |
| rx_filt | output | 1 | Filtered receive level |

## Verification
Several properties are checked on every cycle:
- the counter stays inside its bounds when saturated;
- the clamp after the top value drops;
- each change of the output coincides with the counter standing at an end point;
- every upward step of the counter traces back to a high line three samples earlier.

Other behaviours are shown only by the bench's scenarios:
- exact end-to-end latency for particular codes;
- rejection of glitch trains;
- the full saturation run.

These are covered by directed runs and by seeded random segments. The random segments are compared cycle by cycle against a bench reference model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CODE_W = 3;
    localparam int LOW_W  = 4;
    localparam int CNT_W  = CODE_W + LOW_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic level;
    } filt_st_t;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rxf_threshold.sv
module rxf_threshold
    import rxf_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = LOW_W,
    localparam int TW = CW + LW
) (
    input  logic [CW-1:0] code,
    output logic [TW-1:0] top
);
    // low bits forced to ones, code supplies the upper bits
    always_comb top = {code, {LW{1'b1}}};
endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  cnt_t top,
    output cnt_t count,
    output logic level
);
    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt > top) begin
            st_d.cnt   = top;
            st_d.level = 1'b1;
        end else begin
            if (sample && st_q.cnt != top)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (!sample && st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
            if (st_d.cnt == top)
                st_d.level = 1'b1;
            else if (st_d.cnt == '0)
                st_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign level = st_q.level;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == top && sample) |=> st_q.cnt == $past(st_q.cnt));
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == '0 && !sample) |=> st_q.cnt == '0);
    p_set_at_top_r5: assert property (@(posedge clk) disable iff (rst)
        (sample && st_q.cnt < top && st_q.cnt == top - 1'b1) |=> st_q.level);
    p_clear_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!sample && st_q.cnt == 7'd1 && st_q.cnt <= top) |=> !st_q.level);
    p_rise_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.level) |-> st_q.cnt == $past(top));
    p_fall_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.level) |-> st_q.cnt == '0);
    p_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt > top) |=> (st_q.cnt == $past(top) && st_q.level));
endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter
    import rxf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_raw,
    input  logic [CODE_W-1:0] pre_code,
    output logic              rx_filt
);
    logic rx_sync;
    cnt_t top;
    cnt_t count;

    rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_raw),
        .dout (rx_sync)
    );

    rxf_threshold u_thr (
        .code (pre_code),
        .top  (top)
    );

    rxf_integrator u_int (
        .clk    (clk),
        .rst    (rst),
        .sample (rx_sync),
        .top    (top),
        .count  (count),
        .level  (rx_filt)
    );

    // an upward step of the counter needs a high line three samples back
    p_sync_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (count > $past(count) && $past(count) <= $past(top, 2)) |-> $past(rx_raw, 3));
    p_reset_out_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rx_filt && count == '0));
endmodule

// File: tb/rx_glitch_filter_test.sv
`timescale 1ns/1ps
module rx_glitch_filter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_raw = 1'b0;
    logic [2:0] pre_code = 3'd0;
    logic       rx_filt;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic       m_s1, m_s2, m_lat;
    logic [6:0] m_cnt;

    always #5 clk = ~clk;

    rx_glitch_filter uut (
        .clk      (clk),
        .rst      (rst),
        .rx_raw   (rx_raw),
        .pre_code (pre_code),
        .rx_filt  (rx_filt)
    );

    function automatic logic [6:0] top_of(input logic [2:0] c);
        return {c, 4'hF};
    endfunction

    function automatic logic [6:0] next_cnt(input logic [6:0] c, input logic s,
                                            input logic [6:0] t);
        if (c > t)               return t;
        if (s)                   return (c == t) ? c : c + 7'd1;
        return (c == 7'd0) ? c : c - 7'd1;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rx_filt=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_lat = 0; m_cnt = 0;
    endtask

    // drive at negedge, update model across posedge, compare at next negedge
    task automatic step(input logic rx, input logic [2:0] code, input logic do_chk);
        logic [6:0] t, nc;
        logic       old_lat, clamp;
        rx_raw = rx;
        pre_code = code;
        @(posedge clk);
        t = top_of(code);
        clamp = (m_cnt > t);
        nc = next_cnt(m_cnt, m_s2, t);
        old_lat = m_lat;
        if (clamp)            m_lat = 1'b1;
        else if (nc == t)     m_lat = 1'b1;
        else if (nc == 7'd0)  m_lat = 1'b0;
        m_cnt = nc;
        m_s2 = m_s1;
        m_s1 = rx;
        @(negedge clk);
        if (do_chk) begin
            if (clamp)                   check("R8", rx_filt, m_lat);
            else if (m_lat && !old_lat)  check("R5", rx_filt, m_lat);
            else if (!m_lat && old_lat)  check("R6", rx_filt, m_lat);
            else                         check("R7", rx_filt, m_lat);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_raw = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", rx_filt, 1'b0);
        rst = 1'b0;
        rx_raw = 1'b0;
        model_reset();
    endtask

    // hold a level and report after how many edges the output first equals it
    task automatic time_to(input logic lvl, input logic [2:0] code, output int edges);
        edges = 0;
        do begin
            step(lvl, code, 1'b0);
            edges++;
        end while (rx_filt !== lvl && edges < 400);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e;
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        step(1'b0, 3'd0, 1'b1);
        check("R1", rx_filt, 1'b0);

        // R4/R9: code 2 -> top 0x2F, high from zero reaches output after top+2 edges
        time_to(1'b1, 3'd2, e);
        n_chk++;
        if (e != 8'h2F + 2) begin
            n_fail++;
            $display("FAIL R4 R9: rise after %0d edges expected %0d", e, 8'h2F + 2);
        end

        // R2/R6/R9: fall from top with code 2 after top+2 edges
        time_to(1'b0, 3'd2, e);
        n_chk++;
        if (e != 8'h2F + 2) begin
            n_fail++;
            $display("FAIL R2 R6: fall after %0d edges expected %0d", e, 8'h2F + 2);
        end

        // R4: code 0 -> top 0x0F
        time_to(1'b1, 3'd0, e);
        n_chk++;
        if (e != 8'h0F + 2) begin
            n_fail++;
            $display("FAIL R4: code0 rise after %0d edges expected %0d", e, 8'h0F + 2);
        end
        time_to(1'b0, 3'd0, e);

        // R3: saturate at code 7 for long, then fall must take exactly top+2
        repeat (300) step(1'b1, 3'd7, 1'b0);
        check("R3", rx_filt, 1'b1);
        time_to(1'b0, 3'd7, e);
        n_chk++;
        if (e != 8'h7F + 2) begin
            n_fail++;
            $display("FAIL R3: fall after saturation %0d edges expected %0d", e, 8'h7F + 2);
        end
        // R3: long low hold, then rise takes exactly top+2 (no underflow)
        repeat (200) step(1'b0, 3'd7, 1'b0);
        time_to(1'b1, 3'd7, e);
        n_chk++;
        if (e != 8'h7F + 2) begin
            n_fail++;
            $display("FAIL R3: rise after low hold %0d edges expected %0d", e, 8'h7F + 2);
        end
        time_to(1'b0, 3'd7, e);

        // R7: single-cycle pulses and a short burst never move the output
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 3'd1, 1'b1);
            step(1'b0, 3'd1, 1'b1);
            step(1'b0, 3'd1, 1'b1);
        end
        repeat (20) step(1'b1, 3'd1, 1'b1);
        check("R7", rx_filt, 1'b0);
        repeat (30) step(1'b0, 3'd1, 1'b1);

        // R8: count 38 under code 7, then drop code to 0 -> clamp and set
        repeat (40) step(1'b1, 3'd7, 1'b1);
        check("R8", rx_filt, 1'b0);
        step(1'b1, 3'd0, 1'b1);
        check("R8", rx_filt, 1'b1);
        repeat (30) step(1'b0, 3'd0, 1'b1);

        // random segments checked cycle by cycle against the model
        for (int seg = 0; seg < 250; seg++) begin
            logic [2:0] c;
            int kind, len;
            c = 3'($urandom % 8);
            kind = int'($urandom % 3);
            len = 10 + int'($urandom % 140);
            for (int k = 0; k < len; k++) begin
                logic b;
                case (kind)
                    0: b = (seg % 2 == 0);
                    1: b = ($urandom % 4) != 0;
                    default: b = ($urandom % 2) != 0;
                endcase
                if (($urandom % 200) == 0) c = 3'($urandom % 8);
                step(b, c, 1'b1);
            end
        end

        // R1: reset mid-run clears the output
        repeat (100) step(1'b1, 3'd0, 1'b1);
        do_reset();
        step(1'b1, 3'd0, 1'b1);
        check("R1", rx_filt, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule